// File: doc/BRIEF.md
# EDO DRAM Data-Output Controller

This block models the device side of the data pins of an extended-data-out DRAM. It samples the four active-low strobes (row strobe, column strobe, output enable and write enable) on a system clock. It captures the word that the array would present at the start of a read column access. It produces a registered tri-state enable `dq_oe` and a registered output word `dq_out` that together stand for the bidirectional data pins.

The model holds read data after the column strobe rises, for as long as the row strobe stays low. It gates the output with the output-enable strobe, so that output can be withdrawn and restored within one column access. It classifies each column access as a read, an early write or a late write, and the output stays open for the rest of any write. A memory controller under test connects to it to check that its strobe sequencing produces the data windows it expects.

All strobe inputs are sampled at the rising clock edge. The outputs that follow from the inputs sampled at one edge are visible right after that edge.

Top module: `edo_dq_ctrl`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `dq_oe` is 0 and `dq_out` is all zeros.
- R2: A column-strobe falling edge (`cas_n` sampled 1 and then 0) with `we_n` high starts a read: `rd_data` from that same edge is captured, and it appears on `dq_out` with `dq_oe` at 1 after that edge if `oe_n` is low.
- R3: When `cas_n` rises while `ras_n` stays low, an enabled read output keeps driving the same captured word.
- R4: When `ras_n` and `cas_n` are both sampled high, `dq_oe` is 0 after that edge, and it stays 0 until the next read column access.
- R5: A new word is captured only at a column-strobe falling edge. If `cas_n` is already low when `ras_n` falls, and also whenever `rd_data` changes while `cas_n` stays low, the previously captured word is kept.
- R6: With `oe_n` high, `dq_oe` is 0 after the edge. Lowering `oe_n` again, while the read is still valid, drives the previously captured word again.
- R7: A column-strobe falling edge with `we_n` low is an early write: `dq_oe` stays 0 for the whole column access, whatever `oe_n` does.
- R8: A `we_n` falling edge while `cas_n` stays low in a read, with `oe_n` high, makes the access a late write: `dq_oe` stays 0 until the next column-strobe falling edge, even if `oe_n` goes low again.
- R9: A `we_n` falling edge during a read while `oe_n` is low does not reclassify the access: the output keeps driving.
- R10: With the default `MASK_WHEN_OFF = 1`, `dq_out` is all zeros whenever `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| oe_n | input | 1 | Output enable strobe, active low |
| we_n | input | 1 | Write enable strobe, active low |
| rd_data | input | DATA_W | Word read from the array for the current column |
| dq_oe | output | 1 | Data pins driven when 1, high-impedance when 0 |
| dq_out | output | DATA_W | Word presented on the data pins |

## Verification
Several behaviours are checked by the assertions at every clock edge. Both strobes high turns the output off (R4), a raised output enable turns it off (R6), an early write keeps it off (R7), the rising column strobe keeps the output stable (R3), and the off state carries a zero word (R10). The bench's scenarios are needed for the rest. Those are the capture and re-enable sequences, which tie the driven word to the value captured several cycles earlier (R2, R5, R6). The same holds for the late-write and the late-write-with-enable cases (R8, R9), which depend on how the access was classified several edges before. A random strobe sequence, compared against a bench reference model, covers mixed orderings.

// File: rtl/edo_pkg.sv
package edo_pkg;
   typedef enum logic [1:0] {
      ACC_IDLE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_EARLY = 2'd2,
      ACC_LATE  = 2'd3
   } access_kind_e;

   typedef struct packed {
      logic row_n;
      logic col_n;
      logic oen_n;
      logic wen_n;
   } strobes_t;

   typedef struct packed {
      logic col_fall;
      logic wen_fall;
      logic both_high;
   } strobe_events_t;
endpackage

// File: rtl/edo_strobe_edges.sv
module edo_strobe_edges
   import edo_pkg::*;
(
   input  logic           clk,
   input  logic           rst_n,
   input  strobes_t       strb,
   output strobe_events_t evt
);
   logic col_q;
   logic wen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q <= 1'b1;
         wen_q <= 1'b1;
      end else begin
         col_q <= strb.col_n;
         wen_q <= strb.wen_n;
      end
   end

   always_comb begin
      evt.col_fall  = col_q & ~strb.col_n;
      evt.wen_fall  = wen_q & ~strb.wen_n;
      evt.both_high = strb.row_n & strb.col_n;
   end
endmodule

// File: rtl/edo_access_class.sv
module edo_access_class
   import edo_pkg::*;
(
   input  logic           clk,
   input  logic           rst_n,
   input  strobes_t       strb,
   input  strobe_events_t evt,
   output access_kind_e   kind_nxt
);
   access_kind_e kind_q;

   always_comb begin
      kind_nxt = kind_q;
      if (evt.col_fall) begin
         kind_nxt = strb.wen_n ? ACC_READ : ACC_EARLY;
      end else if (kind_q == ACC_READ && !strb.col_n && evt.wen_fall && strb.oen_n) begin
         kind_nxt = ACC_LATE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) kind_q <= ACC_IDLE;
      else        kind_q <= kind_nxt;
   end
endmodule

// File: rtl/edo_dq_latch.sv
module edo_dq_latch
   import edo_pkg::*;
#(
   parameter int unsigned DATA_W        = 8,
   parameter bit          MASK_WHEN_OFF = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  strobes_t          strb,
   input  strobe_events_t    evt,
   input  access_kind_e      kind_nxt,
   input  logic [DATA_W-1:0] rd_data,
   output logic              drive,
   output logic [DATA_W-1:0] word
);
   localparam logic [DATA_W-1:0] ZERO_WORD = '0;

   logic              held_q;
   logic              held_nxt;
   logic [DATA_W-1:0] data_q;
   logic              drive_q;

   always_comb begin
      held_nxt = held_q;
      if (evt.col_fall)       held_nxt = strb.wen_n;
      else if (evt.both_high) held_nxt = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q  <= 1'b0;
         data_q  <= ZERO_WORD;
         drive_q <= 1'b0;
      end else begin
         held_q  <= held_nxt;
         if (evt.col_fall && strb.wen_n) data_q <= rd_data;
         drive_q <= held_nxt && (kind_nxt == ACC_READ) && !strb.oen_n;
      end
   end

   assign drive = drive_q;

   generate
      if (MASK_WHEN_OFF) begin : g_mask
         assign word = drive_q ? data_q : ZERO_WORD;
      end else begin : g_raw
         assign word = data_q;
      end
   endgenerate
endmodule

// File: rtl/edo_dq_ctrl.sv
module edo_dq_ctrl
   import edo_pkg::*;
#(
   parameter int unsigned DATA_W        = 8,
   parameter bit          MASK_WHEN_OFF = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [DATA_W-1:0] rd_data,
   output logic              dq_oe,
   output logic [DATA_W-1:0] dq_out
);
   generate
      if (DATA_W < 1 || DATA_W > 1024) begin : g_bad_width
         $error("edo_dq_ctrl: DATA_W out of range");
      end
   endgenerate

   strobes_t       strb;
   strobe_events_t evt;
   access_kind_e   kind_nxt;

   assign strb = '{row_n: ras_n, col_n: cas_n, oen_n: oe_n, wen_n: we_n};

   edo_strobe_edges u_edges (
      .clk   (clk),
      .rst_n (rst_n),
      .strb  (strb),
      .evt   (evt)
   );

   edo_access_class u_class (
      .clk      (clk),
      .rst_n    (rst_n),
      .strb     (strb),
      .evt      (evt),
      .kind_nxt (kind_nxt)
   );

   edo_dq_latch #(
      .DATA_W        (DATA_W),
      .MASK_WHEN_OFF (MASK_WHEN_OFF)
   ) u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .strb     (strb),
      .evt      (evt),
      .kind_nxt (kind_nxt),
      .rd_data  (rd_data),
      .drive    (dq_oe),
      .word     (dq_out)
   );
endmodule

// File: rtl/edo_dq_ctrl_chk.sv
module edo_dq_ctrl_chk #(
   parameter int unsigned DATA_W        = 8,
   parameter bit          MASK_WHEN_OFF = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ras_n,
   input logic              cas_n,
   input logic              oe_n,
   input logic              we_n,
   input logic              dq_oe,
   input logic [DATA_W-1:0] dq_out
);
   // R4: both strobes high turns the pins off after the edge
   assert_idle_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ras_n && cas_n) |=> !dq_oe);

   // R6: raised output enable turns the pins off after the edge
   assert_oe_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |=> !dq_oe);

   // R7: early write keeps the pins off
   assert_early_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cas_n) && !we_n) |=> !dq_oe);

   // R3: rising column strobe with row low keeps the driven word
   assert_edo_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cas_n) && !ras_n && !oe_n && dq_oe) |=> (dq_oe && $stable(dq_out)));

   generate
      if (MASK_WHEN_OFF) begin : g_mask_chk
         // R10: off state carries a zero word
         assert_zero_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !dq_oe |-> (dq_out == '0));
      end
   endgenerate
endmodule

bind edo_dq_ctrl edo_dq_ctrl_chk #(
   .DATA_W        (DATA_W),
   .MASK_WHEN_OFF (MASK_WHEN_OFF)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .ras_n  (ras_n),
   .cas_n  (cas_n),
   .oe_n   (oe_n),
   .we_n   (we_n),
   .dq_oe  (dq_oe),
   .dq_out (dq_out)
);

// File: tb/edo_dq_ctrl_test.sv
module edo_dq_ctrl_test;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ras_n = 1'b1, cas_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic [W-1:0] rd_data = '0;
   logic         dq_oe;
   logic [W-1:0] dq_out;

   int n_run = 0;
   int n_fail = 0;

   // reference state: 0 idle, 1 read, 2 early write, 3 late write
   logic         m_pcas = 1'b1, m_pwe = 1'b1, m_valid = 1'b0;
   int           m_kind = 0;
   logic [W-1:0] m_data = '0;
   logic         exp_oe = 1'b0;
   logic [W-1:0] exp_out = '0;

   always #10 clk = ~clk;

   edo_dq_ctrl #(.DATA_W(W)) uut (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
      .oe_n(oe_n), .we_n(we_n), .rd_data(rd_data),
      .dq_oe(dq_oe), .dq_out(dq_out)
   );

   function automatic logic col_fell(logic pc, logic c);
      return pc && !c;
   endfunction

   task automatic model_edge();
      if (col_fell(m_pcas, cas_n)) begin
         if (we_n) begin m_kind = 1; m_valid = 1'b1; m_data = rd_data; end
         else      begin m_kind = 2; m_valid = 1'b0; end
      end else begin
         if (ras_n && cas_n) m_valid = 1'b0;
         if (!cas_n && m_kind == 1 && m_pwe && !we_n && oe_n) m_kind = 3;
      end
      m_pcas  = cas_n;
      m_pwe   = we_n;
      exp_oe  = m_valid && (m_kind == 1) && !oe_n;
      exp_out = exp_oe ? m_data : '0;
   endtask

   task automatic check(string tag);
      n_run++;
      if (dq_oe !== exp_oe || dq_out !== exp_out) begin
         n_fail++;
         $display("FAIL %s: dq_oe=%b dq_out=%h expected dq_oe=%b dq_out=%h",
                  tag, dq_oe, dq_out, exp_oe, exp_out);
      end
   endtask

   // apply strobes now (at a falling clock edge), clock once, check
   task automatic step(logic r, logic c, logic o, logic w, logic [W-1:0] d, string tag);
      ras_n = r; cas_n = c; oe_n = o; we_n = w; rd_data = d;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check(tag);
   endtask

   initial begin
      repeat (300000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      check("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      step(1, 1, 1, 1, 8'h00, "R1 after reset");

      // R2 read capture, R3 hold after column rise
      step(0, 1, 0, 1, 8'h11, "R2 row open");
      step(0, 0, 0, 1, 8'hA5, "R2 capture");
      step(0, 0, 0, 1, 8'h3C, "R5 data change ignored");
      step(0, 1, 0, 1, 8'h77, "R3 hold after cas rise");
      step(0, 1, 0, 1, 8'h77, "R3 hold second cycle");
      step(0, 0, 0, 1, 8'h5A, "R2 next column");
      // R6 output enable toggle
      step(0, 0, 1, 1, 8'h00, "R6 oe high off");
      step(0, 0, 0, 1, 8'hFF, "R6 oe low restores");
      // R4 both high
      step(1, 1, 0, 1, 8'h00, "R4 both high off");
      step(1, 1, 0, 1, 8'h00, "R4 stays off");

      // R5 hidden: cas low when ras falls
      step(0, 1, 0, 1, 8'h00, "R5 row");
      step(0, 0, 0, 1, 8'hC3, "R5 capture");
      step(1, 0, 0, 1, 8'h99, "R5 ras high cas low");
      step(0, 0, 0, 1, 8'h66, "R5 ras falls, cas low keeps");
      step(1, 1, 1, 1, 8'h00, "R4 close");

      // R7 early write
      step(0, 1, 0, 0, 8'h00, "R7 row we low");
      step(0, 0, 0, 0, 8'hE1, "R7 early write off");
      step(0, 0, 0, 1, 8'hE2, "R7 we high still off");
      step(0, 0, 0, 0, 8'hE3, "R7 still off");
      step(1, 1, 1, 1, 8'h00, "R4 close");

      // R8 late write
      step(0, 1, 1, 1, 8'h00, "R8 row");
      step(0, 0, 1, 1, 8'h42, "R8 read oe high");
      step(0, 0, 1, 0, 8'h00, "R8 we falls oe high");
      step(0, 0, 0, 0, 8'h00, "R8 oe low stays off");
      step(0, 0, 0, 1, 8'h00, "R8 still off");
      step(0, 1, 0, 1, 8'h00, "R8 cas rise");
      step(0, 0, 0, 1, 8'h24, "R8 new read drives");

      // R9 we falls with oe low
      step(0, 0, 0, 0, 8'h00, "R9 we falls oe low keeps");
      step(0, 0, 0, 0, 8'h00, "R9 still driving");
      step(1, 1, 1, 1, 8'h00, "R4 close");
      step(1, 1, 1, 1, 8'h00, "R10 off zero word");

      // constrained random mix
      for (int i = 0; i < 3000; i++) begin
         logic r, c, o, w;
         r = ($urandom_range(0, 3) == 0) ? ~ras_n : ras_n;
         c = ($urandom_range(0, 2) == 0) ? ~cas_n : cas_n;
         o = ($urandom_range(0, 4) == 0) ? ~oe_n : oe_n;
         w = ($urandom_range(0, 5) == 0) ? ~we_n : we_n;
         step(r, c, o, w, W'($urandom), "RND R2-mix");
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule